// File: doc/BRIEF.md
# Autobaud Serial Command Receiver

This block takes register-access commands from an external processor over a single serial input line. It does not use a fixed divisor. For every new command it measures the bit period from the low time of the first start bit, then uses that period for the rest of the command and for the reply. A command is always seven characters long: a command code, an address, an index, three data bytes (most significant first) and a checksum. Each character is one start bit, eight data bits sent least significant bit first, and one stop bit.

When the checksum matches, the block raises a one-cycle strobe on its register-access port. The port carries the command, the address, the index and the 24-bit data, and a write/read decode. The block then sends a five-character reply at the measured rate on an output that it enables only while the reply is being sent. A frame whose checksum is wrong raises an error flag and gets no reply. A frame that stalls in the middle is dropped after a configurable number of idle bit times.

Top module: `cua_top`

## Requirements
- R1: The bit period P is the number of clocks that the line stays low at the start of the first character of a frame. The first character must therefore have data bit 0 equal to 1. P is accepted only if CLK_HZ/BAUD_MAX <= P <= CLK_HZ/BAUD_MIN. A low period outside that window produces no character, and a frame sent at such a rate is never accepted.
- R2: P is measured again for every frame. The other six characters of that frame, and its reply, use the P of that frame.
- R3: Characters are 8N1 with the least significant bit first. A frame is, in order: command, address, index, data[23:16], data[15:8], data[7:0], checksum.
- R4: The checksum is the modulo-256 sum of the first six characters. When it matches, reg_valid is high for exactly one cycle. reg_cmd, reg_addr, reg_index and reg_wdata then hold the fields of that frame until the next frame is accepted.
- R5: reg_write is 1 exactly when cmd[7:4] = 4'b0010 and cmd[1:0] = 2'b11. Bits cmd[3:2] are don't-care.
- R6: When the checksum does not match, there is no reg_valid and no reply, and cksum_err goes to 1. cksum_err returns to 0 when the next frame is accepted.
- R7: After an accepted frame the block sends five 8N1 characters, least significant bit first, with no gaps between them: the command, the reply data[23:16], data[15:8], data[7:0], and the modulo-256 sum of those four. The reply data is the written data for a write, and reg_rdata sampled in the reg_valid cycle otherwise. Every bit lasts P clocks, so txd_oe stays high for exactly 50·P cycles.
- R8: txd_oe is 1 only while a reply is being sent. txd is 1 whenever txd_oe is 0.
- R9: If, inside a frame, the line stays idle for more than TIMEOUT_BITS bit periods, the partial frame is dropped. The next character then starts a new frame.
- R10: After reset, txd_oe = 0, txd = 1, reg_valid = 0, cksum_err = 0, and the next character begins a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial command input (asynchronous, idle high) |
| txd | output | 1 | Serial reply data |
| txd_oe | output | 1 | Output enable for txd (tristate control) |
| reg_valid | output | 1 | One-cycle strobe for an accepted command |
| reg_write | output | 1 | Command decodes as a write |
| reg_cmd | output | 8 | Command code of the accepted frame |
| reg_addr | output | 8 | Address field |
| reg_index | output | 8 | Index field |
| reg_wdata | output | 24 | Data field |
| reg_rdata | input | 24 | Read data returned by the register file in the reg_valid cycle |
| cksum_err | output | 1 | Set by a checksum mismatch, cleared by the next accepted frame |

## Verification
The assertions check the following on every cycle: the measured period stays inside the legal window, reg_valid lasts one cycle, a new error never comes with a strobe, the frame index stays within seven characters, the reply period is frozen while the output is enabled, and the line is high whenever it is not driven. Other behaviour only the bench scenarios can show. These are the field order, the write decode across the don't-care bits, the reply contents and the exact 50·P enable length at the minimum, maximum and intermediate periods. The bench also shows that a bad checksum suppresses the strobe and the reply, that a stalled frame is dropped so that a following frame aligns correctly, and that a frame sent too slowly is ignored.

// File: rtl/cua_pkg.sv
package cua_pkg;

    localparam int FRAME_OCTETS = 7;
    localparam int REPLY_OCTETS = 5;
    localparam int CHAR_BITS    = 10;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_MEAS,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_t;

    typedef struct packed {
        logic [7:0]  cmd;
        logic [7:0]  addr;
        logic [7:0]  index;
        logic [23:0] data;
    } cmd_t;

    function automatic logic cmd_is_write(input logic [7:0] c);
        return (c[7:4] == 4'b0010) && (c[1:0] == 2'b11);
    endfunction

    function automatic logic [7:0] sum4(input logic [7:0] a, input logic [7:0] b,
                                        input logic [7:0] c, input logic [7:0] d);
        return a + b + c + d;
    endfunction

endpackage

// File: rtl/cua_rx.sv
module cua_rx
    import cua_pkg::*;
#(
    parameter int MIN_BIT      = 20,
    parameter int MAX_BIT      = 40,
    parameter int TIMEOUT_BITS = 20,
    localparam int CW          = $clog2(MAX_BIT + 2),
    localparam int TW          = $clog2(TIMEOUT_BITS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rxd,
    input  logic          first_octet,
    input  logic          mid_frame,
    input  logic          hold,
    output logic          octet_valid,
    output logic [7:0]    octet,
    output logic          timeout,
    output logic [CW-1:0] bit_len
);

    logic          rxd_m, rxd_s;
    rx_state_t     state;
    logic [CW-1:0] timer;
    logic [CW-1:0] cnt;
    logic [2:0]    bitn;
    logic [7:0]    shreg;
    logic [CW-1:0] idle_clk;
    logic [TW-1:0] idle_bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            rxd_m <= 1'b1;
            rxd_s <= 1'b1;
        end else begin
            rxd_m <= rxd;
            rxd_s <= rxd_m;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= RX_IDLE;
            timer       <= '0;
            cnt         <= '0;
            bitn        <= '0;
            shreg       <= '0;
            octet       <= '0;
            octet_valid <= 1'b0;
            bit_len     <= CW'(MIN_BIT);
        end else begin
            octet_valid <= 1'b0;
            case (state)
                RX_IDLE: begin
                    if (!hold && !rxd_s) begin
                        if (first_octet) begin
                            cnt   <= CW'(1);
                            state <= RX_MEAS;
                        end else begin
                            timer <= (bit_len >> 1) - 1'b1;
                            state <= RX_START;
                        end
                    end
                end
                RX_MEAS: begin
                    if (!rxd_s) begin
                        if (cnt <= CW'(MAX_BIT)) cnt <= cnt + 1'b1;
                    end else if (cnt >= CW'(MIN_BIT) && cnt <= CW'(MAX_BIT)) begin
                        bit_len <= cnt;
                        timer   <= (cnt >> 1) - 1'b1;
                        bitn    <= '0;
                        state   <= RX_DATA;
                    end else begin
                        state <= RX_IDLE;
                    end
                end
                RX_START: begin
                    if (timer == '0) begin
                        if (!rxd_s) begin
                            timer <= bit_len - 1'b1;
                            bitn  <= '0;
                            state <= RX_DATA;
                        end else begin
                            state <= RX_IDLE;
                        end
                    end else begin
                        timer <= timer - 1'b1;
                    end
                end
                RX_DATA: begin
                    if (timer == '0) begin
                        shreg <= {rxd_s, shreg[7:1]};
                        timer <= bit_len - 1'b1;
                        if (bitn == 3'd7) state <= RX_STOP;
                        else              bitn  <= bitn + 1'b1;
                    end else begin
                        timer <= timer - 1'b1;
                    end
                end
                RX_STOP: begin
                    if (timer == '0) begin
                        if (rxd_s) begin
                            octet_valid <= 1'b1;
                            octet       <= shreg;
                        end
                        state <= RX_IDLE;
                    end else begin
                        timer <= timer - 1'b1;
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    // idle-gap watchdog inside a frame, counted in measured bit periods
    always_ff @(posedge clk) begin
        if (rst) begin
            idle_clk  <= '0;
            idle_bits <= '0;
            timeout   <= 1'b0;
        end else begin
            timeout <= 1'b0;
            if (state == RX_IDLE && mid_frame && rxd_s && !timeout) begin
                if (idle_clk == bit_len - 1'b1) begin
                    idle_clk <= '0;
                    if (idle_bits == TW'(TIMEOUT_BITS)) begin
                        idle_bits <= '0;
                        timeout   <= 1'b1;
                    end else begin
                        idle_bits <= idle_bits + 1'b1;
                    end
                end else begin
                    idle_clk <= idle_clk + 1'b1;
                end
            end else begin
                idle_clk  <= '0;
                idle_bits <= '0;
            end
        end
    end

    AST_BITLEN_RANGE: assert property (@(posedge clk) disable iff (rst)
        bit_len >= CW'(MIN_BIT) && bit_len <= CW'(MAX_BIT)); // R1

    AST_TIMEOUT_MID_FRAME: assert property (@(posedge clk) disable iff (rst)
        timeout |-> mid_frame); // R9

endmodule

// File: rtl/cua_frame.sv
module cua_frame
    import cua_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          octet_valid,
    input  logic [7:0]    octet,
    input  logic          timeout,
    input  logic [23:0]   reg_rdata,
    output logic          first_octet,
    output logic          mid_frame,
    output logic          reg_valid,
    output logic          reg_write,
    output cmd_t          fields,
    output logic          cksum_err,
    output logic          tx_start,
    output logic [REPLY_OCTETS*8-1:0] reply
);

    logic [2:0] idx;
    logic [7:0] sum;
    cmd_t       asm_q;
    logic [23:0] rep_data;
    logic [REPLY_OCTETS*8-1:0] reply_next;

    assign first_octet = (idx == 3'd0);
    assign mid_frame   = (idx != 3'd0);

    always_comb begin
        rep_data   = reg_write ? fields.data : reg_rdata;
        reply_next = {sum4(fields.cmd, rep_data[23:16], rep_data[15:8], rep_data[7:0]),
                      rep_data[7:0], rep_data[15:8], rep_data[23:16], fields.cmd};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx       <= '0;
            sum       <= '0;
            asm_q     <= '0;
            fields    <= '0;
            reg_valid <= 1'b0;
            reg_write <= 1'b0;
            cksum_err <= 1'b0;
            tx_start  <= 1'b0;
            reply     <= '0;
        end else begin
            reg_valid <= 1'b0;
            tx_start  <= reg_valid;
            if (reg_valid) reply <= reply_next;
            if (timeout) begin
                idx <= '0;
                sum <= '0;
            end else if (octet_valid) begin
                if (idx == 3'(FRAME_OCTETS - 1)) begin
                    idx <= '0;
                    sum <= '0;
                    if (sum == octet) begin
                        fields    <= asm_q;
                        reg_write <= cmd_is_write(asm_q.cmd);
                        reg_valid <= 1'b1;
                        cksum_err <= 1'b0;
                    end else begin
                        cksum_err <= 1'b1;
                    end
                end else begin
                    sum <= sum + octet;
                    idx <= idx + 1'b1;
                    case (idx)
                        3'd0:    asm_q.cmd   <= octet;
                        3'd1:    asm_q.addr  <= octet;
                        3'd2:    asm_q.index <= octet;
                        default: asm_q.data  <= {asm_q.data[15:0], octet};
                    endcase
                end
            end
        end
    end

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        idx < 3'(FRAME_OCTETS)); // R3

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        reg_valid |=> !reg_valid); // R4

    AST_ERR_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        $rose(cksum_err) |-> !reg_valid); // R6

endmodule

// File: rtl/cua_tx.sv
module cua_tx
    import cua_pkg::*;
#(
    parameter int N_OCT = REPLY_OCTETS,
    parameter int CW    = 6,
    localparam int NB   = N_OCT * CHAR_BITS,
    localparam int BW   = $clog2(NB + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [N_OCT*8-1:0] data,
    input  logic [CW-1:0]   bit_len,
    output logic            txd,
    output logic            txd_oe
);

    logic [NB-1:0] frame_bits;
    logic [NB-1:0] shreg;
    logic          active;
    logic [CW-1:0] len_q;
    logic [CW-1:0] timer;
    logic [BW-1:0] bits_left;

    for (genvar i = 0; i < N_OCT; i++) begin : g_char
        assign frame_bits[i*CHAR_BITS +: CHAR_BITS] = {1'b1, data[i*8 +: 8], 1'b0};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '0;
            active    <= 1'b0;
            len_q     <= '0;
            timer     <= '0;
            bits_left <= '0;
        end else if (!active) begin
            if (start) begin
                shreg     <= frame_bits;
                len_q     <= bit_len;
                timer     <= bit_len - 1'b1;
                bits_left <= BW'(NB);
                active    <= 1'b1;
            end
        end else if (timer == '0) begin
            if (bits_left == BW'(1)) begin
                active <= 1'b0;
            end else begin
                shreg     <= {1'b1, shreg[NB-1:1]};
                bits_left <= bits_left - 1'b1;
                timer     <= len_q - 1'b1;
            end
        end else begin
            timer <= timer - 1'b1;
        end
    end

    assign txd_oe = active;
    assign txd    = active ? shreg[0] : 1'b1;

    AST_LINE_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !txd_oe |-> txd); // R8

    AST_LEN_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active)) |-> $stable(len_q)); // R7

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        start |-> !active); // R7

endmodule

// File: rtl/cua_top.sv
module cua_top
    import cua_pkg::*;
#(
    parameter int CLK_HZ       = 50_000_000,
    parameter int BAUD_MIN     = 19200,
    parameter int BAUD_MAX     = 38400,
    parameter int TIMEOUT_BITS = 20
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rxd,
    output logic        txd,
    output logic        txd_oe,
    output logic        reg_valid,
    output logic        reg_write,
    output logic [7:0]  reg_cmd,
    output logic [7:0]  reg_addr,
    output logic [7:0]  reg_index,
    output logic [23:0] reg_wdata,
    input  logic [23:0] reg_rdata,
    output logic        cksum_err
);

    localparam int MAX_BIT = CLK_HZ / BAUD_MIN;
    localparam int MIN_BIT = CLK_HZ / BAUD_MAX;
    localparam int CW      = $clog2(MAX_BIT + 2);

    logic          octet_valid, timeout, first_octet, mid_frame, tx_start, hold;
    logic [7:0]    octet;
    logic [CW-1:0] bit_len;
    cmd_t          fields;
    logic [REPLY_OCTETS*8-1:0] reply;

    assign hold = txd_oe | tx_start | reg_valid;

    cua_rx #(
        .MIN_BIT(MIN_BIT), .MAX_BIT(MAX_BIT), .TIMEOUT_BITS(TIMEOUT_BITS)
    ) u_rx (
        .clk(clk), .rst(rst), .rxd(rxd),
        .first_octet(first_octet), .mid_frame(mid_frame), .hold(hold),
        .octet_valid(octet_valid), .octet(octet), .timeout(timeout), .bit_len(bit_len)
    );

    cua_frame u_frame (
        .clk(clk), .rst(rst),
        .octet_valid(octet_valid), .octet(octet), .timeout(timeout),
        .reg_rdata(reg_rdata),
        .first_octet(first_octet), .mid_frame(mid_frame),
        .reg_valid(reg_valid), .reg_write(reg_write), .fields(fields),
        .cksum_err(cksum_err), .tx_start(tx_start), .reply(reply)
    );

    cua_tx #(.N_OCT(REPLY_OCTETS), .CW(CW)) u_tx (
        .clk(clk), .rst(rst), .start(tx_start), .data(reply),
        .bit_len(bit_len), .txd(txd), .txd_oe(txd_oe)
    );

    assign reg_cmd   = fields.cmd;
    assign reg_addr  = fields.addr;
    assign reg_index = fields.index;
    assign reg_wdata = fields.data;

endmodule

// File: tb/cua_top_tb.sv
module cua_top_tb;

    localparam int CLK_HZ  = 768_000;
    localparam int TO_BITS = 20;
    localparam int NVEC    = 6;
    // {cmd, addr, index, data, bit period}
    localparam logic [55:0] VEC [NVEC] = '{
        {8'h23, 8'h12, 8'h34, 24'hABCDEF, 8'd20},
        {8'h2F, 8'hFF, 8'h00, 24'h000001, 8'd40},
        {8'h41, 8'h56, 8'h78, 24'h123456, 8'd27},
        {8'h33, 8'h9A, 8'h01, 24'hFEDCBA, 8'd24},
        {8'h2B, 8'h00, 8'hC3, 24'h80FF7F, 8'd33},
        {8'h21, 8'h7E, 8'h81, 24'h5A5A5A, 8'd31}
    };

    logic clk = 1'b0, rst = 1'b1, rxd = 1'b1;
    logic txd, txd_oe, reg_valid, reg_write, cksum_err;
    logic [7:0] reg_cmd, reg_addr, reg_index;
    logic [23:0] reg_wdata, reg_rdata;

    int n_chk = 0, n_fail = 0, val_cnt = 0, rep_cnt = 0, rep_len = 0, cur_len = 20;
    logic [49:0] rep_bits;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    assign reg_rdata = {reg_addr ^ 8'h5A, reg_index, reg_addr + reg_index};

    cua_top #(.CLK_HZ(CLK_HZ), .TIMEOUT_BITS(TO_BITS)) u_dut (
        .clk(clk), .rst(rst), .rxd(rxd), .txd(txd), .txd_oe(txd_oe),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_cmd(reg_cmd),
        .reg_addr(reg_addr), .reg_index(reg_index), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cksum_err(cksum_err)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) if (!rst && reg_valid) val_cnt++;

    initial begin
        forever begin
            @(negedge clk);
            if (txd_oe) begin
                int n;
                logic [49:0] b;
                n = 0;
                b = '0;
                while (txd_oe) begin
                    if ((n % cur_len) == cur_len / 2 && n / cur_len < 50) b[n / cur_len] = txd;
                    n++;
                    @(negedge clk);
                end
                rep_bits = b;
                rep_len  = n;
                rep_cnt++;
            end
        end
    end

    task automatic send_octet(input logic [7:0] v, input int len);
        rxd = 1'b0;
        repeat (len) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            rxd = v[k];
            repeat (len) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (len) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] c, input logic [7:0] a, input logic [7:0] x,
                              input logic [23:0] d, input int len, input logic corrupt);
        logic [7:0] s;
        s = c + a + x + d[23:16] + d[15:8] + d[7:0];
        if (corrupt) s = s + 8'd1;
        cur_len = len;
        send_octet(c, len);
        send_octet(a, len);
        send_octet(x, len);
        send_octet(d[23:16], len);
        send_octet(d[15:8], len);
        send_octet(d[7:0], len);
        send_octet(s, len);
        repeat (60 * len) @(negedge clk);
    endtask

    function automatic logic [39:0] decode_reply(input logic [49:0] b);
        logic [39:0] r;
        for (int k = 0; k < 5; k++) r[k*8 +: 8] = b[k*10+1 +: 8];
        return r;
    endfunction

    function automatic logic [9:0] framing(input logic [49:0] b);
        logic [9:0] f;
        for (int k = 0; k < 5; k++) f[k*2 +: 2] = {b[k*10+9], b[k*10]};
        return f;
    endfunction

    task automatic expect_accept(input string tag, input logic [7:0] c, input logic [7:0] a,
                                 input logic [7:0] x, input logic [23:0] d, input int len,
                                 input int v0, input int r0);
        logic w;
        logic [23:0] rd;
        logic [39:0] er;
        w  = (c[7:4] == 4'b0010) && (c[1:0] == 2'b11);
        rd = w ? d : {a ^ 8'h5A, x, a + x};
        er = {c + rd[23:16] + rd[15:8] + rd[7:0], rd[7:0], rd[15:8], rd[23:16], c};
        check({tag, " R4 strobe count"}, 64'(val_cnt - v0), 64'd1);
        check({tag, " R3 fields"}, {reg_cmd, reg_addr, reg_index, reg_wdata}, {c, a, x, d});
        check({tag, " R5 write decode"}, reg_write, w);
        check({tag, " R7 reply count"}, 64'(rep_cnt - r0), 64'd1);
        check({tag, " R7 reply content"}, decode_reply(rep_bits), er);
        check({tag, " R7 framing"}, framing(rep_bits), 10'b1010101010);
        check({tag, " R2 reply length"}, 64'(rep_len), 64'(50 * len));
        check({tag, " R6 err clear"}, cksum_err, 1'b0);
        check({tag, " R8 idle line"}, {txd_oe, txd}, 2'b01);
    endtask

    initial begin
        int v0, r0;
        repeat (4) @(negedge clk);
        check("R10 txd_oe", txd_oe, 1'b0);
        check("R10 txd", txd, 1'b1);
        check("R10 reg_valid", reg_valid, 1'b0);
        check("R10 cksum_err", cksum_err, 1'b0);
        rst = 1'b0;
        repeat (10) @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            v0 = val_cnt; r0 = rep_cnt;
            send_frame(VEC[i][55:48], VEC[i][47:40], VEC[i][39:32], VEC[i][31:8],
                       int'(VEC[i][7:0]), 1'b0);
            expect_accept($sformatf("vec%0d", i), VEC[i][55:48], VEC[i][47:40],
                          VEC[i][39:32], VEC[i][31:8], int'(VEC[i][7:0]), v0, r0);
        end

        // bad checksum, then recovery
        v0 = val_cnt; r0 = rep_cnt;
        send_frame(8'h23, 8'h44, 8'h55, 24'h666666, 25, 1'b1);
        check("R6 no strobe on bad sum", 64'(val_cnt - v0), 64'd0);
        check("R6 no reply on bad sum", 64'(rep_cnt - r0), 64'd0);
        check("R6 err set", cksum_err, 1'b1);
        v0 = val_cnt; r0 = rep_cnt;
        send_frame(8'h27, 8'h01, 8'h02, 24'h030405, 25, 1'b0);
        expect_accept("R6 recovery", 8'h27, 8'h01, 8'h02, 24'h030405, 25, v0, r0);

        // stalled partial frame is dropped
        cur_len = 30;
        send_octet(8'h23, 30);
        send_octet(8'hAA, 30);
        send_octet(8'hBB, 30);
        repeat ((TO_BITS + 6) * 30) @(negedge clk);
        v0 = val_cnt; r0 = rep_cnt;
        send_frame(8'h2F, 8'h10, 8'h20, 24'h304050, 30, 1'b0);
        expect_accept("R9 after timeout", 8'h2F, 8'h10, 8'h20, 24'h304050, 30, v0, r0);

        // rate slower than the window is ignored
        v0 = val_cnt; r0 = rep_cnt;
        send_frame(8'h23, 8'h11, 8'h22, 24'h334455, 50, 1'b0);
        check("R1 slow rate no strobe", 64'(val_cnt - v0), 64'd0);
        check("R1 slow rate no reply", 64'(rep_cnt - r0), 64'd0);
        v0 = val_cnt; r0 = rep_cnt;
        send_frame(8'h23, 8'h11, 8'h22, 24'h334455, 22, 1'b0);
        expect_accept("R1 legal after slow", 8'h23, 8'h11, 8'h22, 24'h334455, 22, v0, r0);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule